// File: doc/BRIEF.md
# Packed, Saturating and Bit-Field Integer ALU

This block is a single-cycle integer execution unit for one 32-bit lane of a wide processor datapath. Each cycle it takes an opcode, two source operands, a half-width immediate and the current value of the destination register. One clock edge later it presents a result word and a flag that marks a clipped saturating result. There is no handshake, because the unit registers a result every cycle.

The unit covers these operations:

- Halfword-pair arithmetic, where the two lanes never exchange a carry.
- Signed saturating add and subtract.
- Register-counted shifts, including a saturating left shift.
- A leftmost-matching-bit search and a redundant-sign-bit count.
- Compares that produce a 0/1 word.
- Clearing or setting a bit range.
- A two-step constant build. The low move sign-extends a 16-bit constant. The high move then overwrites only the upper half and keeps the lower half from the destination input.

Top module: `pack_sat_alu`

## Requirements
- R1: Outputs are registered. While `rstN` is low at a rising edge, `result` and `satFlag` become 0 after that edge. Otherwise an operation presented before a rising edge appears on the outputs just after that edge and not before it.
- R2: Opcode 0 (pair add) gives `src1 + src2` and opcode 1 (pair subtract) gives `src1 - src2`, each computed separately on bits [15:0] and bits [31:16] modulo 2^16, with no carry or borrow between the halves.
- R3: Opcode 2 (saturating add, `src1 + src2`) and opcode 3 (saturating subtract, `src1 - src2`) treat the operands as signed. A result that overflows becomes 0x7FFFFFFF or 0x80000000, whichever has the sign of the true result, and `satFlag` is 1. Without overflow the result is exact and `satFlag` is 0.
- R4: Opcode 4 (arithmetic right shift) and opcode 5 (logical right shift) shift `src2` by the count in `src1[5:0]`. Bits of `src1` above bit 5 are ignored. A count of 32 or more gives all copies of the sign bit for the arithmetic shift and 0 for the logical shift.
- R5: Opcode 6 (saturating left shift) shifts `src2` left by `src1[5:0]`. If the shifted value no longer represents `src2 * 2^count` as a signed word, the result is 0x7FFFFFFF for a non-negative `src2` or 0x80000000 for a negative one, and `satFlag` is 1. A nonzero `src2` with a count of 32 or more always clips, and a zero `src2` never does.
- R6: Opcode 7 (leftmost match) returns the index, from 0 to 31, of the highest bit of `src2` equal to `src1[0]`. If no bit matches it returns 32.
- R7: Opcode 8 (normalise) returns the number of bits directly below bit 31 of `src2` that equal bit 31. The result lies in 0..31, so both 0 and 0xFFFFFFFF give 31.
- R8: Opcodes 9 (equal), 10 (signed greater), 11 (unsigned greater), 12 (signed less) and 13 (unsigned less) compare `src1` against `src2`. They return 1 when the condition holds and 0 otherwise.
- R9: Opcode 14 clears and opcode 15 sets bits [hi:lo] of `src1`, where lo = `src2[4:0]` and hi = `src2[9:5]`. When lo > hi, `src1` passes through unchanged.
- R10: Opcode 16 (low constant) returns `imm` sign-extended to 32 bits and ignores `dstIn`.
- R11: Opcode 17 (high constant) returns `{imm, dstIn[15:0]}`. A low-constant result fed back as `dstIn` to a high-constant operation therefore builds any 32-bit value.
- R12: `satFlag` is 0 for every opcode other than 2, 3 and 6. Unused opcodes (18 to 31) give a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| op | input | 5 | Operation code |
| src1 | input | DATA_W | First source operand |
| src2 | input | DATA_W | Second source operand (shifted, searched or compared value) |
| imm | input | DATA_W/2 | Constant for the low and high constant moves |
| dstIn | input | DATA_W | Current destination value, used by the high constant move |
| result | output | DATA_W | Registered result word |
| satFlag | output | 1 | Registered flag, high when a saturating operation clipped |

## Verification
The bench builds the unit with the default `DATA_W` of 32, which gives 16-bit lanes, a 6-bit shift-count field and 5-bit field positions. At this width the count field reaches 32 to 63, so shifts past the word width can be tested. Both clamp values, 0x7FFFFFFF and 0x80000000, and the no-match value of 32 for the leftmost search can be written directly as vectors. The field positions also reach bit 31, so a range covering the whole word and a one-bit range at the top bit can both be exercised.

// File: rtl/pack_sat_alu_pkg.sv
package pack_sat_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD2    = 5'd0,
    OP_SUB2    = 5'd1,
    OP_SADD    = 5'd2,
    OP_SSUB    = 5'd3,
    OP_SHRA    = 5'd4,
    OP_SHRL    = 5'd5,
    OP_SSHL    = 5'd6,
    OP_LMATCH  = 5'd7,
    OP_NORM    = 5'd8,
    OP_CMPEQ   = 5'd9,
    OP_CMPGT   = 5'd10,
    OP_CMPGTU  = 5'd11,
    OP_CMPLT   = 5'd12,
    OP_CMPLTU  = 5'd13,
    OP_FCLR    = 5'd14,
    OP_FSET    = 5'd15,
    OP_CONSTLO = 5'd16,
    OP_CONSTHI = 5'd17
  } opcode_e;

  typedef enum logic [2:0] {
    U_NONE, U_PACK, U_SAT, U_SHIFT, U_SCAN, U_CMP, U_FIELD, U_CONST
  } unit_e;

  typedef enum logic [2:0] {
    C_EQ, C_GT, C_GTU, C_LT, C_LTU
  } cmp_e;

  typedef struct packed {
    unit_e unit;
    logic  sub;       // subtract instead of add
    logic  shArith;   // right shift fills with sign
    logic  shLeft;    // saturating left shift
    logic  scanNorm;  // scanner counts sign bits
    cmp_e  cmpSel;
    logic  fieldSet;  // set instead of clear
    logic  constHi;   // insert upper half
  } ctrl_t;

endpackage

// File: rtl/pack_sat_alu_ctrl.sv
module pack_sat_alu_ctrl
  import pack_sat_alu_pkg::*;
(
  input  logic [4:0] opIn,
  output ctrl_t      ctl
);

  always_comb begin
    ctl = '{unit: U_NONE, sub: 1'b0, shArith: 1'b0, shLeft: 1'b0,
            scanNorm: 1'b0, cmpSel: C_EQ, fieldSet: 1'b0, constHi: 1'b0};
    case (opIn)
      OP_ADD2:    ctl.unit = U_PACK;
      OP_SUB2:    begin ctl.unit = U_PACK;  ctl.sub = 1'b1; end
      OP_SADD:    ctl.unit = U_SAT;
      OP_SSUB:    begin ctl.unit = U_SAT;   ctl.sub = 1'b1; end
      OP_SHRA:    begin ctl.unit = U_SHIFT; ctl.shArith = 1'b1; end
      OP_SHRL:    ctl.unit = U_SHIFT;
      OP_SSHL:    begin ctl.unit = U_SHIFT; ctl.shLeft = 1'b1; end
      OP_LMATCH:  ctl.unit = U_SCAN;
      OP_NORM:    begin ctl.unit = U_SCAN;  ctl.scanNorm = 1'b1; end
      OP_CMPEQ:   begin ctl.unit = U_CMP;   ctl.cmpSel = C_EQ;  end
      OP_CMPGT:   begin ctl.unit = U_CMP;   ctl.cmpSel = C_GT;  end
      OP_CMPGTU:  begin ctl.unit = U_CMP;   ctl.cmpSel = C_GTU; end
      OP_CMPLT:   begin ctl.unit = U_CMP;   ctl.cmpSel = C_LT;  end
      OP_CMPLTU:  begin ctl.unit = U_CMP;   ctl.cmpSel = C_LTU; end
      OP_FCLR:    ctl.unit = U_FIELD;
      OP_FSET:    begin ctl.unit = U_FIELD; ctl.fieldSet = 1'b1; end
      OP_CONSTLO: ctl.unit = U_CONST;
      OP_CONSTHI: begin ctl.unit = U_CONST; ctl.constHi = 1'b1; end
      default:    ctl.unit = U_NONE;
    endcase
  end

endmodule

// File: rtl/pack_sat_alu_scan.sv
module pack_sat_alu_scan #(
  parameter int W = 32,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  input  logic             target,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  // The highest matching position wins because the loop runs upward.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i] == target) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/pack_sat_alu_dp.sv
module pack_sat_alu_dp
  import pack_sat_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W  = DATA_W / 2,
  localparam int SHAMT_W = $clog2(DATA_W) + 1,
  localparam int POS_W   = $clog2(DATA_W),
  localparam int LANES   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] src2,
  input  logic [HALF_W-1:0] imm,
  input  logic [DATA_W-1:0] dstIn,
  output logic [DATA_W-1:0] result,
  output logic              satFlag
);

  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  // Halfword pair arithmetic: each lane is carry-isolated
  logic [DATA_W-1:0] packRes;
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [HALF_W-1:0] laneA, laneB;
    assign laneA = src1[l*HALF_W +: HALF_W];
    assign laneB = src2[l*HALF_W +: HALF_W];
    assign packRes[l*HALF_W +: HALF_W] = ctl.sub ? laneA - laneB : laneA + laneB;
  end

  // Saturating add/sub with one guard bit
  logic signed [DATA_W:0] wideA, wideB, wideSum;
  logic                   satClip;
  logic [DATA_W-1:0]      satRes;
  assign wideA   = {src1[DATA_W-1], src1};
  assign wideB   = {src2[DATA_W-1], src2};
  assign wideSum = ctl.sub ? wideA - wideB : wideA + wideB;
  assign satClip = wideSum[DATA_W] != wideSum[DATA_W-1];
  assign satRes  = satClip ? (wideSum[DATA_W] ? MIN_NEG : MAX_POS) : wideSum[DATA_W-1:0];

  // Shifts, count from the low bits of src1
  logic [SHAMT_W-1:0] shAmt;
  logic [DATA_W-1:0]  asrRes, lsrRes, shlRaw, shlBack, shlRes, shiftRes;
  logic               shlClip;
  assign shAmt   = src1[SHAMT_W-1:0];
  assign asrRes  = $signed(src2) >>> shAmt;
  assign lsrRes  = src2 >> shAmt;
  assign shlRaw  = src2 << shAmt;
  assign shlBack = $signed(shlRaw) >>> shAmt;
  assign shlClip = shlBack != src2;
  assign shlRes  = shlClip ? (src2[DATA_W-1] ? MIN_NEG : MAX_POS) : shlRaw;
  assign shiftRes = ctl.shLeft ? shlRes : (ctl.shArith ? asrRes : lsrRes);

  // Shared bit scanner: leftmost match, or first bit differing from the sign
  logic             scanTarget, scanHit;
  logic [POS_W-1:0] scanIdx;
  logic [DATA_W-1:0] scanRes;
  assign scanTarget = ctl.scanNorm ? ~src2[DATA_W-1] : src1[0];

  pack_sat_alu_scan #(.W(DATA_W)) u_scan (
    .vec    (src2),
    .target (scanTarget),
    .hit    (scanHit),
    .idx    (scanIdx)
  );

  always_comb begin
    if (ctl.scanNorm)
      scanRes = scanHit ? DATA_W'(DATA_W - 2) - DATA_W'(scanIdx) : DATA_W'(DATA_W - 1);
    else
      scanRes = scanHit ? DATA_W'(scanIdx) : DATA_W'(DATA_W);
  end

  // Compares to a 0/1 word
  logic cmpBit;
  always_comb begin
    case (ctl.cmpSel)
      C_EQ:    cmpBit = src1 == src2;
      C_GT:    cmpBit = $signed(src1) > $signed(src2);
      C_GTU:   cmpBit = src1 > src2;
      C_LT:    cmpBit = $signed(src1) < $signed(src2);
      C_LTU:   cmpBit = src1 < src2;
      default: cmpBit = 1'b0;
    endcase
  end

  // Bit-range clear/set
  logic [POS_W-1:0]  fieldLo, fieldHi;
  logic [DATA_W-1:0] fieldMask, fieldRes;
  assign fieldLo = src2[POS_W-1:0];
  assign fieldHi = src2[2*POS_W-1:POS_W];
  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    assign fieldMask[b] = (fieldLo <= POS_W'(b)) && (POS_W'(b) <= fieldHi);
  end
  assign fieldRes = ctl.fieldSet ? (src1 | fieldMask) : (src1 & ~fieldMask);

  // Two-step constant build
  logic [DATA_W-1:0] constRes;
  assign constRes = ctl.constHi ? {imm, dstIn[HALF_W-1:0]}
                                : {{HALF_W{imm[HALF_W-1]}}, imm};

  // Result select and output register
  logic [DATA_W-1:0] nextRes;
  logic              nextFlag;
  always_comb begin
    nextFlag = 1'b0;
    case (ctl.unit)
      U_PACK:  nextRes = packRes;
      U_SAT:   begin nextRes = satRes; nextFlag = satClip; end
      U_SHIFT: begin nextRes = shiftRes; nextFlag = ctl.shLeft & shlClip; end
      U_SCAN:  nextRes = scanRes;
      U_CMP:   nextRes = {{(DATA_W-1){1'b0}}, cmpBit};
      U_FIELD: nextRes = fieldRes;
      U_CONST: nextRes = constRes;
      default: nextRes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result  <= '0;
      satFlag <= 1'b0;
    end else begin
      result  <= nextRes;
      satFlag <= nextFlag;
    end
  end

endmodule

// File: rtl/pack_sat_alu.sv
module pack_sat_alu
  import pack_sat_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        op,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] src2,
  input  logic [HALF_W-1:0] imm,
  input  logic [DATA_W-1:0] dstIn,
  output logic [DATA_W-1:0] result,
  output logic              satFlag
);

  ctrl_t ctl;

  pack_sat_alu_ctrl u_ctrl (
    .opIn (op),
    .ctl  (ctl)
  );

  pack_sat_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .src1    (src1),
    .src2    (src2),
    .imm     (imm),
    .dstIn   (dstIn),
    .result  (result),
    .satFlag (satFlag)
  );

endmodule

// File: rtl/pack_sat_alu_chk.sv
module pack_sat_alu_chk
  import pack_sat_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [4:0]        op,
  input logic [DATA_W-1:0] src1,
  input logic [DATA_W-1:0] src2,
  input logic [HALF_W-1:0] imm,
  input logic [DATA_W-1:0] dstIn,
  input logic [DATA_W-1:0] result,
  input logic              satFlag
);

  localparam logic [DATA_W-1:0] MAX_POS = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  AST_PAIR_LOW_LANE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(op) == 5'(OP_ADD2)) |->
      result[HALF_W-1:0] == HALF_W'($past(src1[HALF_W-1:0]) + $past(src2[HALF_W-1:0]))); // R2

  AST_CLAMP_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    satFlag |-> (result == MAX_POS || result == MIN_NEG)); // R3

  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && satFlag) |->
      ($past(op) == 5'(OP_SADD) || $past(op) == 5'(OP_SSUB) || $past(op) == 5'(OP_SSHL))); // R12

  AST_LMATCH_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(op) == 5'(OP_LMATCH)) |-> result <= DATA_W'(DATA_W)); // R6

  AST_NORM_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(op) == 5'(OP_NORM)) |-> result <= DATA_W'(DATA_W - 1)); // R7

  AST_CMP_BOOLEAN: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(op) >= 5'(OP_CMPEQ) && $past(op) <= 5'(OP_CMPLTU)) |->
      result[DATA_W-1:1] == '0); // R8

  AST_CONSTLO_SEXT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(op) == 5'(OP_CONSTLO)) |->
      (result[HALF_W-1:0] == $past(imm) && result[DATA_W-1:HALF_W] == {HALF_W{result[HALF_W-1]}})); // R10

  AST_CONSTHI_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(op) == 5'(OP_CONSTHI)) |->
      (result[DATA_W-1:HALF_W] == $past(imm) && result[HALF_W-1:0] == $past(dstIn[HALF_W-1:0]))); // R11

endmodule

bind pack_sat_alu pack_sat_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .op      (op),
  .src1    (src1),
  .src2    (src2),
  .imm     (imm),
  .dstIn   (dstIn),
  .result  (result),
  .satFlag (satFlag)
);

// File: tb/pack_sat_alu_tb.sv
module pack_sat_alu_tb;
  import pack_sat_alu_pkg::*;

  localparam int DATA_W = 32;
  localparam int HALF_W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rstN;
  logic [4:0]        op;
  logic [DATA_W-1:0] src1, src2, dstIn;
  logic [HALF_W-1:0] imm;
  logic [DATA_W-1:0] result;
  logic              satFlag;

  pack_sat_alu #(.DATA_W(DATA_W)) u_dut (
    .clk (clk), .rstN (rstN), .op (op), .src1 (src1), .src2 (src2),
    .imm (imm), .dstIn (dstIn), .result (result), .satFlag (satFlag)
  );

  int nChecks = 0;
  int nFails  = 0;

  typedef struct packed {
    logic [4:0]  req;
    logic [4:0]  code;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] k;
    logic [31:0] d;
    logic [31:0] expRes;
    logic        expFlag;
  } vec_t;

  localparam int NV = 45;
  localparam vec_t VECS [NV] = '{
    '{5'd2,  OP_ADD2,    32'h7FFF0001, 32'h0001FFFF, 16'h0, 32'h0, 32'h80000000, 1'b0}, // R2
    '{5'd2,  OP_SUB2,    32'h00000000, 32'h00010001, 16'h0, 32'h0, 32'hFFFFFFFF, 1'b0}, // R2
    '{5'd2,  OP_SUB2,    32'h00050003, 32'h00020004, 16'h0, 32'h0, 32'h0003FFFF, 1'b0}, // R2
    '{5'd3,  OP_SADD,    32'h7FFFFFFF, 32'h00000001, 16'h0, 32'h0, 32'h7FFFFFFF, 1'b1}, // R3
    '{5'd3,  OP_SADD,    32'h80000000, 32'hFFFFFFFF, 16'h0, 32'h0, 32'h80000000, 1'b1}, // R3
    '{5'd3,  OP_SADD,    32'h00000005, 32'hFFFFFFFD, 16'h0, 32'h0, 32'h00000002, 1'b0}, // R3
    '{5'd3,  OP_SSUB,    32'h80000000, 32'h00000001, 16'h0, 32'h0, 32'h80000000, 1'b1}, // R3
    '{5'd3,  OP_SSUB,    32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, 32'h0, 32'h7FFFFFFF, 1'b1}, // R3
    '{5'd3,  OP_SSUB,    32'h0000000A, 32'h00000003, 16'h0, 32'h0, 32'h00000007, 1'b0}, // R3
    '{5'd4,  OP_SHRA,    32'h00000004, 32'h80000010, 16'h0, 32'h0, 32'hF8000001, 1'b0}, // R4
    '{5'd4,  OP_SHRA,    32'h00000040, 32'h80000010, 16'h0, 32'h0, 32'h80000010, 1'b0}, // R4
    '{5'd4,  OP_SHRA,    32'h00000028, 32'h80000000, 16'h0, 32'h0, 32'hFFFFFFFF, 1'b0}, // R4
    '{5'd4,  OP_SHRA,    32'h00000028, 32'h7FFFFFFF, 16'h0, 32'h0, 32'h00000000, 1'b0}, // R4
    '{5'd4,  OP_SHRL,    32'h00000004, 32'h80000010, 16'h0, 32'h0, 32'h08000001, 1'b0}, // R4
    '{5'd4,  OP_SHRL,    32'h00000020, 32'hFFFFFFFF, 16'h0, 32'h0, 32'h00000000, 1'b0}, // R4
    '{5'd5,  OP_SSHL,    32'h00000004, 32'h00000123, 16'h0, 32'h0, 32'h00001230, 1'b0}, // R5
    '{5'd5,  OP_SSHL,    32'h00000001, 32'h40000000, 16'h0, 32'h0, 32'h7FFFFFFF, 1'b1}, // R5
    '{5'd5,  OP_SSHL,    32'h00000004, 32'hF8000000, 16'h0, 32'h0, 32'h80000000, 1'b0}, // R5
    '{5'd5,  OP_SSHL,    32'h00000028, 32'hFFFFFFFF, 16'h0, 32'h0, 32'h80000000, 1'b1}, // R5
    '{5'd5,  OP_SSHL,    32'h00000028, 32'h00000000, 16'h0, 32'h0, 32'h00000000, 1'b0}, // R5
    '{5'd6,  OP_LMATCH,  32'h00000001, 32'h00010000, 16'h0, 32'h0, 32'h00000010, 1'b0}, // R6
    '{5'd6,  OP_LMATCH,  32'h00000000, 32'hFFFFFFFF, 16'h0, 32'h0, 32'h00000020, 1'b0}, // R6
    '{5'd6,  OP_LMATCH,  32'h00000000, 32'h7FFFFFFF, 16'h0, 32'h0, 32'h0000001F, 1'b0}, // R6
    '{5'd6,  OP_LMATCH,  32'h00000003, 32'h00000000, 16'h0, 32'h0, 32'h00000020, 1'b0}, // R6
    '{5'd7,  OP_NORM,    32'h00000000, 32'h00000000, 16'h0, 32'h0, 32'h0000001F, 1'b0}, // R7
    '{5'd7,  OP_NORM,    32'h00000000, 32'hFFFFFFFF, 16'h0, 32'h0, 32'h0000001F, 1'b0}, // R7
    '{5'd7,  OP_NORM,    32'h00000000, 32'h00010000, 16'h0, 32'h0, 32'h0000000E, 1'b0}, // R7
    '{5'd7,  OP_NORM,    32'h00000000, 32'h80000000, 16'h0, 32'h0, 32'h00000000, 1'b0}, // R7
    '{5'd7,  OP_NORM,    32'h00000000, 32'hFFFF8000, 16'h0, 32'h0, 32'h00000010, 1'b0}, // R7
    '{5'd8,  OP_CMPEQ,   32'h00000005, 32'h00000005, 16'h0, 32'h0, 32'h00000001, 1'b0}, // R8
    '{5'd8,  OP_CMPEQ,   32'h00000005, 32'h00000006, 16'h0, 32'h0, 32'h00000000, 1'b0}, // R8
    '{5'd8,  OP_CMPGT,   32'h00000001, 32'hFFFFFFFF, 16'h0, 32'h0, 32'h00000001, 1'b0}, // R8
    '{5'd8,  OP_CMPGTU,  32'h00000001, 32'hFFFFFFFF, 16'h0, 32'h0, 32'h00000000, 1'b0}, // R8
    '{5'd8,  OP_CMPLT,   32'h80000000, 32'h00000000, 16'h0, 32'h0, 32'h00000001, 1'b0}, // R8
    '{5'd8,  OP_CMPLTU,  32'h80000000, 32'h00000000, 16'h0, 32'h0, 32'h00000000, 1'b0}, // R8
    '{5'd8,  OP_CMPGT,   32'h00000007, 32'h00000007, 16'h0, 32'h0, 32'h00000000, 1'b0}, // R8
    '{5'd9,  OP_FCLR,    32'hFFFFFFFF, 32'h000000E4, 16'h0, 32'h0, 32'hFFFFFF0F, 1'b0}, // R9
    '{5'd9,  OP_FCLR,    32'hFFFFFFFF, 32'h00000068, 16'h0, 32'h0, 32'hFFFFFFFF, 1'b0}, // R9
    '{5'd9,  OP_FCLR,    32'hFFFFFFFF, 32'h000003E0, 16'h0, 32'h0, 32'h00000000, 1'b0}, // R9
    '{5'd9,  OP_FSET,    32'h00000000, 32'h000001E8, 16'h0, 32'h0, 32'h0000FF00, 1'b0}, // R9
    '{5'd9,  OP_FSET,    32'h00000000, 32'h000003FF, 16'h0, 32'h0, 32'h80000000, 1'b0}, // R9
    '{5'd10, OP_CONSTLO, 32'h00000000, 32'h00000000, 16'hFABC, 32'h87654321, 32'hFFFFFABC, 1'b0}, // R10
    '{5'd10, OP_CONSTLO, 32'h00000000, 32'h00000000, 16'h1234, 32'h87654321, 32'h00001234, 1'b0}, // R10
    '{5'd11, OP_CONSTHI, 32'h00000000, 32'h00000000, 16'h1234, 32'h87654321, 32'h12344321, 1'b0}, // R11
    '{5'd12, 5'd31,      32'h00000005, 32'h00000005, 16'h7, 32'h7, 32'h00000000, 1'b0}  // R12
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] c, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] k, input logic [31:0] d);
    @(negedge clk);
    op = c; src1 = a; src2 = b; imm = k; dstIn = d;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  logic [31:0] held;

  initial begin
    rstN = 1'b0;
    op = OP_SADD; src1 = 32'h7FFFFFFF; src2 = 32'h1; imm = '0; dstIn = '0;
    repeat (3) @(posedge clk);
    #1;
    check(1, "reset result", result, 32'h0);             // R1
    check(1, "reset flag", {31'b0, satFlag}, 32'h0);     // R1

    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    check(1, "first op after reset", result, 32'h7FFFFFFF); // R1
    check(3, "flag after reset", {31'b0, satFlag}, 32'h1);  // R3

    // R1: a new operation shows only after the next edge
    drive(OP_CONSTLO, 32'h0, 32'h0, 16'h0001, 32'h0);
    #1;
    check(1, "before edge holds old", result, 32'h7FFFFFFF);
    @(posedge clk); #1;
    check(1, "after edge new value", result, 32'h00000001);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].code, VECS[i].a, VECS[i].b, VECS[i].k, VECS[i].d);
      @(posedge clk); #1;
      check(int'(VECS[i].req), $sformatf("vector %0d result", i), result, VECS[i].expRes);
      check(int'(VECS[i].req), $sformatf("vector %0d flag", i),
            {31'b0, satFlag}, {31'b0, VECS[i].expFlag});
    end

    // R11: low move result fed back into high move
    drive(OP_CONSTLO, 32'h0, 32'h0, 16'hFABC, 32'hDEADBEEF);
    @(posedge clk); #1;
    held = result;
    drive(OP_CONSTHI, 32'h0, 32'h0, 16'h1234, held);
    @(posedge clk); #1;
    check(11, "constant chain", result, 32'h1234FABC);

    // R12: flag drops once a non-saturating op follows a clip
    drive(OP_SSHL, 32'h1, 32'h40000000, 16'h0, 32'h0);
    @(posedge clk); #1;
    drive(OP_ADD2, 32'h7FFFFFFF, 32'h1, 16'h0, 32'h0);
    @(posedge clk); #1;
    check(12, "flag after pair add", {31'b0, satFlag}, 32'h0);
    check(2, "pair add no carry", result, 32'h7FFF0000);

    // R1: reset in mid-stream clears outputs
    drive(OP_SADD, 32'h7FFFFFFF, 32'h1, 16'h0, 32'h0);
    @(posedge clk); #1;
    @(negedge clk) rstN = 1'b0;
    @(posedge clk); #1;
    check(1, "mid reset result", result, 32'h0);
    check(1, "mid reset flag", {31'b0, satFlag}, 32'h0);

    summary();
    $finish;
  end

endmodule